// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives characters on a half-duplex asynchronous smart card line. Each character on the line is a start bit, eight data bits sent least significant first, a parity bit and then an error-signal slot. The receiver times everything from an oversampling tick that pulses `OSR` times per elementary time unit (ETU). It samples each bit at its mid-point and checks even parity over the data and parity bits. When the parity check fails, it pulls the line low during the error-signal slot so that the sending card retransmits the character.

The received byte is placed in a receive data register. Three sticky flags report the result: receive-full, parity error and overrun. A character with a parity error still loads the data register, but it never sets receive-full. Software clears each flag with its own strobe, and a read-acknowledge strobe also clears receive-full. The block raises a receive interrupt when receive-full is set and the enable is on. It raises an error interrupt while the parity-error or overrun flag is set.

Top module: `sc_char_rx`

## Requirements
- R1: A character is detected on a falling edge of the synchronised line in idle. Data bits are sampled one ETU apart at bit mid-points and assembled least significant bit first, so the first data bit received lands in `rx_data_o[0]`.
- R2: When the eight data bits plus the parity bit hold an even number of ones, the character is good. If receive-full was clear, receive-full sets, the parity-error flag stays 0 and the byte is loaded.
- R3: When the parity check fails, `line_pull_o` is asserted for exactly `ERR_LEN` ticks. It rises `OSR/2` ticks after the parity sample, which is `3 + OSR*(8+1) + OSR` clock cycles after the start edge when the tick is high every cycle (`line_pull_o` = 1 means pull the line low). A good character never asserts it.
- R4: A character with a parity error sets the parity-error flag, leaves receive-full unchanged (never sets it) and still writes its data bits into the data register.
- R5: A good character that completes while receive-full is already set sets the overrun flag, keeps receive-full set and leaves the data register holding its previous byte.
- R6: `clr_full_i`, `clr_par_i` and `clr_ovr_i` each clear only their own flag. `rd_ack_i` also clears receive-full.
- R7: `rx_irq_o` is high exactly while receive-full is set and `rx_ie_i` is 1.
- R8: `err_irq_o` is high exactly while the parity-error flag or the overrun flag is set.
- R9: If the line is back high at the mid-point of the start bit, the receiver returns to idle without changing any flag or the data register, and it then receives the next character normally.
- R10: After reset all flags are 0, the data register is 0, both interrupts are low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick_i | input | 1 | Oversampling tick, OSR pulses per ETU |
| line_i | input | 1 | Serial I/O line level |
| line_pull_o | output | 1 | 1 = drive the open-drain line low |
| rx_data_o | output | 8 | Receive data register |
| rx_full_o | output | 1 | Receive-full flag |
| par_err_o | output | 1 | Parity-error flag |
| ovr_err_o | output | 1 | Overrun flag |
| clr_full_i | input | 1 | Strobe that clears receive-full |
| clr_par_i | input | 1 | Strobe that clears parity-error |
| clr_ovr_i | input | 1 | Strobe that clears overrun |
| rd_ack_i | input | 1 | Data-register read strobe, clears receive-full |
| rx_ie_i | input | 1 | Receive interrupt enable |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Assertions check the flag bookkeeping on every cycle at the moment a character completes. They check that a good character sets receive-full or raises overrun while freezing the data register, and that a bad character sets parity-error, loads the register and never sets receive-full. They also check that every error pulse lasts exactly `ERR_LEN` ticks. Only the bench scenarios can show the things that depend on the line waveform: least-significant-first bit order over every byte value, the exact start cycle of the error pulse relative to the start edge, recovery from a false start, and the effect of the clear strobes and interrupt enable.

// File: rtl/sc_rx_pkg.sv
// Shared definitions for the smart card character receiver.
// Assumes eight data bits per character with one even parity bit.
package sc_rx_pkg;
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GAP,
        ST_SIGNAL
    } rx_state_t;
endpackage

// File: rtl/sc_rx_sync.sv
// Synchroniser for the asynchronous serial line.
// Assumes the line idles high; every stage resets to 1 so reset shows no edge.
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/sc_rx_framer.sv
// Character framer: detects the start edge, samples bits at mid-point,
// checks even parity and drives the error signal after a bad parity bit.
// Assumes tick pulses OSR times per ETU and the input is already synchronised.
module sc_rx_framer
    import sc_rx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int ERR_LEN = 24,
    parameter int DW      = DATA_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_s,
    output logic          pull_o,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o
);
    localparam int HALF    = OSR / 2;
    localparam int CNT_MAX = (OSR > ERR_LEN) ? OSR : ERR_LEN;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int IW      = (DW > 1) ? $clog2(DW) : 1;

    rx_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] shreg_q;
    logic          prev_q;
    logic          perr_q;
    logic          done_q;
    logic          pull_q;
    logic          fall;

    assign fall = prev_q & ~rx_s;

    // Remember the previous line level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= rx_s;
    end

    // Frame sequencer: start check, data shift, parity, gap, error signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            perr_q  <= 1'b0;
            done_q  <= 1'b0;
            pull_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt_q == CW'(HALF - 1)) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (cnt_q == CW'(OSR - 1)) begin
                            cnt_q   <= '0;
                            shreg_q <= {rx_s, shreg_q[DW-1:1]};
                            if (idx_q == IW'(DW - 1)) state_q <= ST_PARITY;
                            else                      idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (tick) begin
                        if (cnt_q == CW'(OSR - 1)) begin
                            cnt_q   <= '0;
                            perr_q  <= ^{shreg_q, rx_s};
                            done_q  <= 1'b1;
                            state_q <= ST_GAP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (cnt_q == CW'(HALF - 1)) begin
                            cnt_q <= '0;
                            if (perr_q) begin
                                state_q <= ST_SIGNAL;
                                pull_q  <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SIGNAL: begin
                    if (tick) begin
                        if (cnt_q == CW'(ERR_LEN - 1)) begin
                            cnt_q   <= '0;
                            pull_q  <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pull_o = pull_q;
    assign done_o = done_q;
    assign data_o = shreg_q;
    assign perr_o = perr_q;

    // Checker counter: ticks spent pulling the line low in the current pulse.
    logic [CW-1:0] pull_ticks_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !pull_q) pull_ticks_q <= '0;
        else if (tick)         pull_ticks_q <= pull_ticks_q + 1'b1;
    end

    AST_ERR_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_q) |-> (pull_ticks_q == CW'(ERR_LEN)));      // R3
    AST_NO_PULL_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !perr_q) |=> !pull_q);                       // R3
endmodule

// File: rtl/sc_rx_flags.sv
// Receive data register, sticky status flags and interrupt requests.
// Assumes done is a one-cycle pulse with data and perr valid alongside it.
module sc_rx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          perr,
    input  logic          clr_full,
    input  logic          clr_par,
    input  logic          clr_ovr,
    input  logic          rd_ack,
    input  logic          rie,
    output logic [DW-1:0] rdr,
    output logic          rdrf,
    output logic          perr_f,
    output logic          orer,
    output logic          rx_irq,
    output logic          err_irq
);
    logic good_done;
    assign good_done = done & ~perr;

    // Update the data register and the three flags; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr    <= '0;
            rdrf   <= 1'b0;
            perr_f <= 1'b0;
            orer   <= 1'b0;
        end else begin
            if (done && (perr || !rdrf)) rdr <= data;

            if (good_done && !rdrf)       rdrf <= 1'b1;
            else if (clr_full || rd_ack)  rdrf <= 1'b0;

            if (done && perr)             perr_f <= 1'b1;
            else if (clr_par)             perr_f <= 1'b0;

            if (good_done && rdrf)        orer <= 1'b1;
            else if (clr_ovr)             orer <= 1'b0;
        end
    end

    assign rx_irq  = rdrf & rie;
    assign err_irq = perr_f | orer;

    AST_GOOD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (good_done && !rdrf) |=> (rdrf && rdr == $past(data)));  // R2
    AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && perr && !rdrf) |=> !rdrf);                      // R4
    AST_ERR_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && perr) |=> (perr_f && rdr == $past(data)));      // R4
    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (good_done && rdrf) |=> (orer && $stable(rdr)));         // R5
endmodule

// File: rtl/sc_char_rx.sv
// Top of the smart card character receiver: synchroniser, framer, flags.
// Assumes an open-drain line; line_pull_o = 1 means drive the line low.
module sc_char_rx #(
    parameter int OSR     = 16,
    parameter int ERR_LEN = 24,
    parameter int SYNC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick_i,
    input  logic       line_i,
    output logic       line_pull_o,
    output logic [7:0] rx_data_o,
    output logic       rx_full_o,
    output logic       par_err_o,
    output logic       ovr_err_o,
    input  logic       clr_full_i,
    input  logic       clr_par_i,
    input  logic       clr_ovr_i,
    input  logic       rd_ack_i,
    input  logic       rx_ie_i,
    output logic       rx_irq_o,
    output logic       err_irq_o
);
    import sc_rx_pkg::*;

    logic                 rx_s;
    logic                 done;
    logic                 perr;
    logic [DATA_BITS-1:0] data;

    sc_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_i),
        .dout (rx_s)
    );

    sc_rx_framer #(.OSR(OSR), .ERR_LEN(ERR_LEN), .DW(DATA_BITS)) u_framer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick_i),
        .rx_s  (rx_s),
        .pull_o(line_pull_o),
        .done_o(done),
        .data_o(data),
        .perr_o(perr)
    );

    sc_rx_flags #(.DW(DATA_BITS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .data    (data),
        .perr    (perr),
        .clr_full(clr_full_i),
        .clr_par (clr_par_i),
        .clr_ovr (clr_ovr_i),
        .rd_ack  (rd_ack_i),
        .rie     (rx_ie_i),
        .rdr     (rx_data_o),
        .rdrf    (rx_full_o),
        .perr_f  (par_err_o),
        .orer    (ovr_err_o),
        .rx_irq  (rx_irq_o),
        .err_irq (err_irq_o)
    );

    AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (par_err_o || ovr_err_o));                 // R8
endmodule

// File: tb/tb_sc_char_rx.sv
module tb_sc_char_rx;
    localparam int OSR     = 8;
    localparam int ERR_LEN = 12;
    localparam int GUARD   = 4 * OSR;
    localparam int PULL_AT = 3 + OSR * 9 + OSR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card = 1'b1;
    logic       line;
    logic       pull;
    logic [7:0] rdr;
    logic       full, perr, ovr, rxi, erri;
    logic       clr_full = 0, clr_par = 0, clr_ovr = 0, rd_ack = 0, rie = 0;

    int tests = 0, fails = 0;
    int cyc = 0, start_cyc = 0, pull_cnt = 0, first_pull = -1;

    assign line = card & ~pull;

    sc_char_rx #(.OSR(OSR), .ERR_LEN(ERR_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .os_tick_i(1'b1), .line_i(line),
        .line_pull_o(pull), .rx_data_o(rdr), .rx_full_o(full),
        .par_err_o(perr), .ovr_err_o(ovr), .clr_full_i(clr_full),
        .clr_par_i(clr_par), .clr_ovr_i(clr_ovr), .rd_ack_i(rd_ack),
        .rx_ie_i(rie), .rx_irq_o(rxi), .err_irq_o(erri)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (pull) begin
        pull_cnt <= pull_cnt + 1;
        if (first_pull < 0) first_pull <= cyc - start_cyc;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit bad);
        logic par;
        par = ^d ^ bad;
        @(negedge clk);
        pull_cnt = 0; first_pull = -1; start_cyc = cyc;
        card = 1'b0;
        repeat (OSR) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            card = d[i];
            repeat (OSR) @(negedge clk);
        end
        card = par;
        repeat (OSR) @(negedge clk);
        card = 1'b1;
        repeat (GUARD) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clr_full = 1;
            1: clr_par  = 1;
            2: clr_ovr  = 1;
            default: rd_ack = 1;
        endcase
        @(negedge clk);
        clr_full = 0; clr_par = 0; clr_ovr = 0; rd_ack = 0;
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 full", full, 0);   chk("R10 perr", perr, 0);
        chk("R10 ovr", ovr, 0);     chk("R10 rdr", rdr, 0);
        chk("R10 pull", pull, 0);   chk("R10 irqs", {rxi, erri}, 0);

        // R1 R2 R7: every byte with good parity
        for (int d = 0; d < 256; d++) begin
            rie = d[0];
            send(d[7:0], 1'b0);
            chk("R1 data", rdr, d);
            chk("R2 full", full, 1);
            chk("R2 perr", perr, 0);
            chk("R3 no pull on good", pull_cnt, 0);
            chk("R7 rx_irq", rxi, d % 2);
            strobe((d % 2 == 0) ? 3 : 0);
            chk("R6 full cleared", full, 0);
            chk("R7 rx_irq low", rxi, 0);
        end

        // R3 R4 R8: every byte with bad parity
        rie = 1;
        for (int d = 0; d < 256; d++) begin
            send(d[7:0], 1'b1);
            chk("R3 pull length", pull_cnt, ERR_LEN);
            chk("R3 pull start", first_pull, PULL_AT);
            chk("R4 perr", perr, 1);
            chk("R4 no full", full, 0);
            chk("R4 data loaded", rdr, d);
            chk("R8 err_irq", erri, 1);
            strobe(1);
            chk("R6 perr cleared", perr, 0);
            chk("R8 err_irq low", erri, 0);
        end

        // R5 R6: overrun, then individual clears
        send(8'h3C, 1'b0);
        send(8'hA5, 1'b0);
        chk("R5 ovr", ovr, 1);
        chk("R5 rdr kept", rdr, 8'h3C);
        chk("R5 full kept", full, 1);
        chk("R8 err_irq ovr", erri, 1);
        strobe(2);
        chk("R6 ovr cleared", ovr, 0);
        chk("R6 full untouched", full, 1);
        // parity error while full: data loaded, full kept
        send(8'h81, 1'b1);
        chk("R4 rdr while full", rdr, 8'h81);
        chk("R4 full stays", full, 1);
        chk("R6 no ovr", ovr, 0);
        strobe(1);
        chk("R6 full survives clr_par", full, 1);
        strobe(0);
        chk("R6 clr_full", full, 0);
        chk("R6 perr after clr", perr, 0);

        // R9: false start
        @(negedge clk);
        card = 1'b0;
        repeat (2) @(negedge clk);
        card = 1'b1;
        repeat (GUARD * 3) @(negedge clk);
        chk("R9 no full", full, 0);
        chk("R9 no perr", perr, 0);
        chk("R9 no ovr", ovr, 0);
        chk("R9 rdr", rdr, 8'h81);
        send(8'h5A, 1'b0);
        chk("R9 recovers data", rdr, 8'h5A);
        chk("R9 recovers full", full, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule